// File: doc/BRIEF.md
# Port Pin-Change Interrupt Detector

This block watches the input pins of a bank of 8-bit I/O ports and raises interrupt requests when a selected pin changes level in a selected direction. The pins fall into two groups. The general group is several 8-bit ports, each of which has one edge-direction setting that covers all eight of its pins. The dedicated port is a single 8-bit port whose pins each have their own edge-direction setting. Every pin also has its own enable bit. Both groups use the same edge rule: a rising edge is a 0-to-1 change and a falling edge is a 1-to-0 change.

Each pin input first passes through a two-flop synchronizer. The detector then compares the synchronized value with the value it held one cycle earlier. When an enabled pin shows a change in its chosen direction, the detector sets a sticky pending flag for that pin. Each group drives one request line, which is high whenever any pending flag in that group is set. Firmware sets the enables and directions through a small write-only register port. It reads the pending flags directly from the outputs and clears each group with a one-cycle strobe.

Top module: `pinchg_irq`

## Requirements
- R1: After reset every pending flag is 0, both request lines are low, every enable bit is 0 and every direction bit is 0.
- R2: A pin change made before clock edge k shows up in its pending flag after edge k+2, and not after edge k or edge k+1.
- R3: A pin whose enable bit is 0 never sets its pending flag, whatever its edges.
- R4: On the general ports, bit p of the general-direction register selects the edge for all 8 pins of port p: 1 means rising, 0 means falling. An edge in the other direction sets nothing.
- R5: On the dedicated port, bit i of the dedicated-direction register selects the edge for pin i alone: 1 means rising, 0 means falling.
- R6: A pending flag stays set until its group's clear strobe is high at a clock edge. A clear of one group leaves the other group's flags unchanged.
- R7: When a qualifying edge is detected at the same clock edge as its group's clear strobe, the flag for that edge ends up set, and every other flag in the group ends up cleared.
- R8: The general request line is the OR of all general pending flags, and the dedicated request line is the OR of the dedicated pending flags. Each line therefore falls only after a clear.
- R9: Register addresses with 4 general ports are as follows. Addresses 0 to 3 hold the enable byte of general port 0 to 3. Address 4 holds the general-direction register in bits 3:0. Address 5 holds the dedicated enable byte. Address 6 holds the dedicated-direction byte. A write to address 7 changes nothing.
- R10: General pin 8*p+i, which is pin i of port p, maps to general pending bit 8*p+i. Dedicated pin i maps to dedicated pending bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gp_pins | input | NUM_GP*8 | Raw levels of the general port pins |
| sp_pins | input | 8 | Raw levels of the dedicated port pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | 8 | Register write data |
| gp_clr | input | 1 | Clears all general pending flags |
| sp_clr | input | 1 | Clears all dedicated pending flags |
| gp_pend | output | NUM_GP*8 | General pending flags |
| sp_pend | output | 8 | Dedicated pending flags |
| gp_irq | output | 1 | General interrupt request |
| sp_irq | output | 1 | Dedicated interrupt request |

## Verification
The bench measures the exact latency from a pin change to its pending flag. A design with one synchronizer stage too many or too few would set the flag one edge late or one edge early. It also drives a pin that is in the wrong direction for its port. A design that applied a port's direction bit to the wrong port, or read it as inverted, would set flags on the wrong edges. It lines up an edge detection with a clear strobe in the same cycle, and checks that a clear of one group leaves the other group alone. A design where the clear took priority would lose that interrupt, and a shared clear would wipe both groups. Finally, it writes all ones to the unused address. A decoder that aliases that address onto the dedicated enable register would then let masked pins set flags. Long random runs compare every output against a cycle-level model kept in the bench.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;

  localparam int unsigned PORT_W = 8;

  // Per-port qualifying edges: a bit is set when the pin is enabled, its
  // level changed, and the new level matches its direction (1 = rising).
  function automatic logic [PORT_W-1:0] edge_hits(
    input logic [PORT_W-1:0] cur,
    input logic [PORT_W-1:0] prev,
    input logic [PORT_W-1:0] dir,
    input logic [PORT_W-1:0] en
  );
    return en & ((cur & ~prev & dir) | (~cur & prev & ~dir));
  endfunction

  // Pending update: clear drops old flags, new hits always survive.
  function automatic logic [PORT_W-1:0] pend_next(
    input logic [PORT_W-1:0] pend,
    input logic [PORT_W-1:0] hits,
    input logic              clr
  );
    return clr ? hits : (pend | hits);
  endfunction

endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/pinchg_regs.sv
module pinchg_regs #(
  parameter int unsigned NUM_GP = 4,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned GPW = NUM_GP * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [GPW-1:0]    gp_en_o,
  output logic [NUM_GP-1:0] gp_dir_o,
  output logic [7:0]        sp_en_o,
  output logic [7:0]        sp_dir_o
);

  localparam logic [ADDR_W-1:0] A_GP_DIR = ADDR_W'(NUM_GP);
  localparam logic [ADDR_W-1:0] A_SP_EN  = ADDR_W'(NUM_GP + 1);
  localparam logic [ADDR_W-1:0] A_SP_DIR = ADDR_W'(NUM_GP + 2);

  logic [GPW-1:0]    gp_en_q;
  logic [NUM_GP-1:0] gp_dir_q;
  logic [7:0]        sp_en_q;
  logic [7:0]        sp_dir_q;

  genvar p;
  generate
    for (p = 0; p < NUM_GP; p++) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          gp_en_q[p*8 +: 8] <= '0;
        else if (wr_i && addr_i == ADDR_W'(p))
          gp_en_q[p*8 +: 8] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_dir_q <= '0;
      sp_en_q  <= '0;
      sp_dir_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_GP_DIR) gp_dir_q <= wdata_i[NUM_GP-1:0];
      if (addr_i == A_SP_EN)  sp_en_q  <= wdata_i;
      if (addr_i == A_SP_DIR) sp_dir_q <= wdata_i;
    end
  end

  assign gp_en_o  = gp_en_q;
  assign gp_dir_o = gp_dir_q;
  assign sp_en_o  = sp_en_q;
  assign sp_dir_o = sp_dir_q;

endmodule

// File: rtl/pinchg_group.sv
module pinchg_group
  import pinchg_pkg::*;
#(
  parameter int unsigned NPORT = 1,
  localparam int unsigned W = NPORT * PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);

  logic [W-1:0] hit;
  logic [W-1:0] pend_q;

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      assign hit[p*PORT_W +: PORT_W] =
        edge_hits(cur_i[p*PORT_W +: PORT_W], prev_i[p*PORT_W +: PORT_W],
                  dir_i[p*PORT_W +: PORT_W], en_i[p*PORT_W +: PORT_W]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q[p*PORT_W +: PORT_W] <= '0;
        else pend_q[p*PORT_W +: PORT_W] <=
          pend_next(pend_q[p*PORT_W +: PORT_W], hit[p*PORT_W +: PORT_W], clr_i);
      end
    end
  endgenerate

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_chk
      // R3
      mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[b]) |-> $past(en_i[b]));
      // R5
      edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[b]) |-> ($past(cur_i[b]) == $past(dir_i[b])));
      // R6
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[b] && !clr_i) |=> pend_q[b]);
      // R7
      edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && en_i[b] && (cur_i[b] != prev_i[b]) && (cur_i[b] == dir_i[b]))
        |=> pend_q[b]);
    end
  endgenerate

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(clr_i));

endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
  import pinchg_pkg::*;
#(
  parameter int unsigned NUM_GP = 4,
  parameter int unsigned ADDR_W = $clog2(NUM_GP + 3),
  localparam int unsigned GPW = NUM_GP * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPW-1:0]    gp_pins,
  input  logic [7:0]        sp_pins,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              gp_clr,
  input  logic              sp_clr,
  output logic [GPW-1:0]    gp_pend,
  output logic [7:0]        sp_pend,
  output logic              gp_irq,
  output logic              sp_irq
);

  logic [GPW-1:0]    gp_cur, gp_prev, gp_en, gp_pin_dir;
  logic [NUM_GP-1:0] gp_dir;
  logic [7:0]        sp_cur, sp_prev, sp_en, sp_dir;

  pinchg_sync #(.W(GPW)) u_gp_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(gp_pins), .cur_o(gp_cur), .prev_o(gp_prev)
  );

  pinchg_sync #(.W(8)) u_sp_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(sp_pins), .cur_o(sp_cur), .prev_o(sp_prev)
  );

  pinchg_regs #(.NUM_GP(NUM_GP), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .gp_en_o(gp_en), .gp_dir_o(gp_dir), .sp_en_o(sp_en), .sp_dir_o(sp_dir)
  );

  // One direction bit per general port fans out to its eight pins.
  genvar p;
  generate
    for (p = 0; p < NUM_GP; p++) begin : g_dir
      assign gp_pin_dir[p*PORT_W +: PORT_W] = {PORT_W{gp_dir[p]}};
    end
  endgenerate

  pinchg_group #(.NPORT(NUM_GP)) u_gp_grp (
    .clk(clk), .rst_n(rst_n), .cur_i(gp_cur), .prev_i(gp_prev), .dir_i(gp_pin_dir),
    .en_i(gp_en), .clr_i(gp_clr), .pend_o(gp_pend), .irq_o(gp_irq)
  );

  pinchg_group #(.NPORT(1)) u_sp_grp (
    .clk(clk), .rst_n(rst_n), .cur_i(sp_cur), .prev_i(sp_prev), .dir_i(sp_dir),
    .en_i(sp_en), .clr_i(sp_clr), .pend_o(sp_pend), .irq_o(sp_irq)
  );

  // R6
  cross_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_clr && !gp_clr) |=> ((gp_pend & $past(gp_pend)) == $past(gp_pend)));

endmodule

// File: tb/pinchg_irq_tb.sv
module pinchg_irq_tb;

  localparam int NG = 4;
  localparam int GW = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [GW-1:0] gp_pins = '0;
  logic [7:0]    sp_pins = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic          gp_clr = 1'b0, sp_clr = 1'b0;
  logic [GW-1:0] gp_pend;
  logic [7:0]    sp_pend;
  logic          gp_irq, sp_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pinchg_irq #(.NUM_GP(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .gp_pins(gp_pins), .sp_pins(sp_pins),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .gp_clr(gp_clr), .sp_clr(sp_clr), .gp_pend(gp_pend), .sp_pend(sp_pend),
    .gp_irq(gp_irq), .sp_irq(sp_irq)
  );

  // ---- cycle-level reference model ----
  logic [GW-1:0] m_g1, m_g2, m_g3, m_gen, m_gpend;
  logic [NG-1:0] m_gdir;
  logic [7:0]    m_s1, m_s2, m_s3, m_sen, m_sdir, m_spend;

  function automatic logic [GW-1:0] m_hits(input logic [GW-1:0] now, input logic [GW-1:0] old,
                                           input logic [GW-1:0] rise, input logic [GW-1:0] en);
    logic [GW-1:0] r;
    for (int i = 0; i < GW; i++)
      r[i] = en[i] && (now[i] != old[i]) && (now[i] == rise[i]);
    return r;
  endfunction

  function automatic logic [GW-1:0] m_expand(input logic [NG-1:0] d);
    logic [GW-1:0] r;
    for (int i = 0; i < GW; i++) r[i] = d[i/8];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_g1 <= '0; m_g2 <= '0; m_g3 <= '0; m_gen <= '0; m_gpend <= '0; m_gdir <= '0;
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_sen <= '0; m_sdir <= '0; m_spend <= '0;
    end else begin
      m_g1 <= gp_pins; m_g2 <= m_g1; m_g3 <= m_g2;
      m_s1 <= sp_pins; m_s2 <= m_s1; m_s3 <= m_s2;
      m_gpend <= (gp_clr ? '0 : m_gpend) | m_hits(m_g2, m_g3, m_expand(m_gdir), m_gen);
      m_spend <= (sp_clr ? '0 : m_spend) |
                 8'(m_hits(GW'(m_s2), GW'(m_s3), GW'(m_sdir), GW'(m_sen)));
      if (reg_wr) begin
        if (reg_addr < 3'(NG)) m_gen[reg_addr*8 +: 8] <= reg_wdata;
        else if (reg_addr == 3'd4) m_gdir <= reg_wdata[NG-1:0];
        else if (reg_addr == 3'd5) m_sen <= reg_wdata;
        else if (reg_addr == 3'd6) m_sdir <= reg_wdata;
      end
    end
  end

  // ---- check helpers ----
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 gp_pend", 64'(gp_pend), 64'h0);
    check("R1 sp_pend", 64'(sp_pend), 64'h0);
    check("R1 irqs", {62'h0, gp_irq, sp_irq}, 64'h0);

    wr(3'd6, 8'h01);          // R9 dedicated direction: pin0 rising, pin2 falling
    wr(3'd5, 8'h05);          // R9 dedicated enables: pins 0 and 2

    // R2 latency: flag appears after the third edge
    sp_pins[0] = 1'b1;
    tick(1); check("R2 after edge k", 64'(sp_pend), 64'h0);
    tick(1); check("R2 after edge k+1", 64'(sp_pend), 64'h0);
    tick(1); check("R2 after edge k+2", 64'(sp_pend), 64'h01);
    check("R8 sp_irq high", 64'(sp_irq), 64'h1);

    // R3 disabled pin is ignored
    sp_pins[1] = 1'b1; tick(4);
    check("R3 masked pin", 64'(sp_pend), 64'h01);

    // R5 per-pin direction: pin2 only on falling
    sp_pins[2] = 1'b1; tick(4);
    check("R5 wrong edge", 64'(sp_pend), 64'h01);
    sp_pins[2] = 1'b0; tick(4);
    check("R5 falling edge", 64'(sp_pend), 64'h05);

    // R6 flag is sticky
    sp_pins[0] = 1'b0; tick(6);
    check("R6 sticky", 64'(sp_pend), 64'h05);

    // R4 per-port direction on the general group
    wr(3'd4, 8'h05);          // ports 0,2 rising; ports 1,3 falling
    for (int p = 0; p < NG; p++) wr(3'(p), 8'hFF);
    gp_pins[11] = 1'b1; tick(4);
    check("R4 port1 rising ignored", 64'(gp_pend), 64'h0);
    check("R8 gp_irq low", 64'(gp_irq), 64'h0);
    gp_pins[11] = 1'b0; gp_pins[16] = 1'b1; tick(4);
    check("R4 R10 port1 fall, port2 rise", 64'(gp_pend), 64'h10800);
    check("R8 gp_irq high", 64'(gp_irq), 64'h1);

    // R6 clearing one group leaves the other
    sp_clr = 1'b1; tick(1); sp_clr = 1'b0;
    check("R6 sp cleared", 64'(sp_pend), 64'h0);
    check("R8 sp_irq low", 64'(sp_irq), 64'h0);
    check("R6 gp untouched", 64'(gp_pend), 64'h10800);

    // R7 edge detected during a clear survives
    gp_pins[0] = 1'b1; tick(2);
    gp_clr = 1'b1; tick(1); gp_clr = 1'b0;
    check("R7 edge wins", 64'(gp_pend), 64'h1);
    gp_clr = 1'b1; tick(1); gp_clr = 1'b0;
    check("R6 gp cleared", 64'(gp_pend), 64'h0);
    check("R8 gp_irq low after clear", 64'(gp_irq), 64'h0);

    // R9 unused address writes nothing
    wr(3'd5, 8'h00);
    wr(3'd7, 8'hFF);
    sp_pins = 8'hFF; tick(4);
    sp_pins = 8'h00; tick(4);
    check("R9 unused address", 64'(sp_pend), 64'h0);

    // R1..R10 random phase against the model
    for (int n = 0; n < 4000; n++) begin
      check("R10 gp_pend model", 64'(gp_pend), 64'(m_gpend));
      check("R10 sp_pend model", 64'(sp_pend), 64'(m_spend));
      check("R8 irq model", {62'h0, gp_irq, sp_irq}, {62'h0, |m_gpend, |m_spend});
      if ($urandom_range(3) == 0) gp_pins = gp_pins ^ ($urandom() & $urandom());
      if ($urandom_range(3) == 0) sp_pins = sp_pins ^ 8'($urandom() & $urandom());
      gp_clr = ($urandom_range(15) == 0);
      sp_clr = ($urandom_range(15) == 0);
      reg_wr = ($urandom_range(9) == 0);
      reg_addr = 3'($urandom_range(7));
      reg_wdata = 8'($urandom());
      tick(1);
    end
    gp_clr = 1'b0; sp_clr = 1'b0; reg_wr = 1'b0;
    tick(1);
    finish_run();
  end

endmodule